// File: doc/BRIEF.md
# Configuration DMA Command Queue

This block is the command front end of a configuration DMA engine. Software describes a transfer by writing four staging registers: source address, destination address, source length and destination length. The write to the destination length register turns the staged values into one command and pushes it into a small command FIFO. A sequencer takes commands one at a time in arrival order, reads one 32-bit word per length unit from memory over a simple request/response word interface, and offers each word on a configuration data stream with valid/ready handshaking.

When a command has delivered its last word, the block pulses a DMA-done event toward the interrupt logic. Bit 0 of the source address is not part of the address: it asks the command to hold completion until the configuration port reports that it has drained, and such a command also pulses a port-done event. Readback is not handled here, so a command is only accepted when the destination address carries the all-ones "no destination" code and the destination length is zero; anything else is discarded and flagged. A push into a full queue is discarded and flagged as an overflow.

Top module: `cfgdma_cmdq`

## Requirements
- R1: Writes to offset 0x18 (source address), 0x1C (destination address) and 0x20 (source length) only update staging registers: they start no memory request and no stream transfer, and the queue stays empty.
- R2: A write to offset 0x24 (destination length) pushes one command built from the staged values, so q_empty is low half a cycle after that write's clock edge.
- R3: A command fetches from the source address with bit 0 cleared, adding 4 per word, and emits exactly as many words as the source length, whose width is 27 bits (write data bits 26:0; higher bits are ignored); each stream word equals the memory response for its fetch address.
- R4: The queue holds DEPTH (default 4) commands; commands run strictly in push order, one at a time; q_full is high while DEPTH commands wait and q_full and q_empty are never both high.
- R5: A push while q_full is high is discarded, leaves the queued commands unchanged, and raises evt_queue_ovf for one cycle, in the cycle after the write.
- R6: evt_dma_done pulses for exactly one cycle once per completed command, after its last word is accepted.
- R7: A command with source length 0 completes without any memory request or stream transfer.
- R8: With source address bit 0 set, evt_dma_done waits until port_idle is high, and evt_port_done pulses in the same cycle as evt_dma_done; with bit 0 clear, port_idle is ignored and evt_port_done stays low.
- R9: A push is accepted only if the staged destination address is 0xFFFFFFFF and the destination length written is 0; otherwise the command is discarded and evt_cmd_err pulses for one cycle, in the cycle after the write.
- R10: While cfg_valid is high and cfg_ready is low, cfg_valid stays high and cfg_data is unchanged in the next cycle.
- R11: After reset the queue is empty and not full, and no memory request, stream word or event is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register byte offset |
| wr_data | input | 32 | Register write data |
| mem_req | output | 1 | Memory word read request, held until answered |
| mem_addr | output | 32 | Memory word address |
| mem_rsp_valid | input | 1 | Memory response valid for the current request |
| mem_rsp_data | input | 32 | Memory response word |
| cfg_valid | output | 1 | Configuration stream word valid |
| cfg_data | output | 32 | Configuration stream word |
| cfg_ready | input | 1 | Configuration stream ready |
| port_idle | input | 1 | Configuration port has drained |
| q_full | output | 1 | Command queue full |
| q_empty | output | 1 | Command queue empty |
| evt_dma_done | output | 1 | Command completed pulse |
| evt_port_done | output | 1 | Port-drain completion pulse for flagged commands |
| evt_queue_ovf | output | 1 | Push into full queue pulse |
| evt_cmd_err | output | 1 | Rejected command pulse |

## Verification
On every cycle the assertions check the stream hold rule, that the queue never reads full and empty together, that fetches never carry the flag bit in their address, that fetching and streaming never overlap, that done pulses last one cycle, that port-done only comes with DMA-done, and that an overflow only follows a full queue. Only the bench scenarios can show the word values and counts per command, the order of queued commands, the discarding on overflow and on a bad destination, zero-length completion and the port-drain wait, which it sweeps over lengths and stream back-pressure patterns.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 27;

    localparam int OFS_SRC  = 'h18;
    localparam int OFS_DST  = 'h1C;
    localparam int OFS_SLEN = 'h20;
    localparam int OFS_DLEN = 'h24;

    localparam logic [WORD_W-1:0] NO_DEST = '1;
    localparam logic [WORD_W-1:0] WORD_STEP = WORD_W'(4);

    typedef struct packed {
        logic [WORD_W-1:0] base;
        logic              hold_port;
        logic [LEN_W-1:0]  words;
    } cmd_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_SEND,
        SQ_WAITP,
        SQ_FIN
    } sq_state_e;

    function automatic cmd_t make_cmd(logic [WORD_W-1:0] src, logic [LEN_W-1:0] n);
        cmd_t c;
        c.base      = {src[WORD_W-1:1], 1'b0};
        c.hold_port = src[0];
        c.words     = n;
        return c;
    endfunction

    function automatic logic is_no_dest(logic [WORD_W-1:0] dst, logic [WORD_W-1:0] dlen);
        return (dst == NO_DEST) && (dlen == '0);
    endfunction

    function automatic sq_state_e after_last(logic hold);
        return hold ? SQ_WAITP : SQ_FIN;
    endfunction

endpackage

// File: rtl/cfgdma_regstage.sv
module cfgdma_regstage
    import cfgdma_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              push_req,
    output logic              push_legal,
    output cmd_t              push_cmd
);

    logic [WORD_W-1:0] src_q;
    logic [WORD_W-1:0] dst_q;
    logic [LEN_W-1:0]  slen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= NO_DEST;
            slen_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_AW'(OFS_SRC))  src_q  <= wr_data;
            if (wr_addr == REG_AW'(OFS_DST))  dst_q  <= wr_data;
            if (wr_addr == REG_AW'(OFS_SLEN)) slen_q <= wr_data[LEN_W-1:0];
        end
    end

    always_comb begin
        push_req   = wr_en && (wr_addr == REG_AW'(OFS_DLEN));
        push_legal = is_no_dest(dst_q, wr_data);
        push_cmd   = make_cmd(src_q, slen_q);
    end

endmodule

// File: rtl/cfgdma_cmd_fifo.sv
module cfgdma_cmd_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 60
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/cfgdma_seq.sv
module cfgdma_seq
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_avail,
    input  cmd_t              cmd_in,
    output logic              cmd_pop,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              cfg_valid,
    output logic [WORD_W-1:0] cfg_data,
    input  logic              cfg_ready,
    input  logic              port_idle,
    output logic              done_pulse,
    output logic              port_done_pulse
);

    sq_state_e         state;
    logic [WORD_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;
    logic              hold_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            addr_q <= '0;
            left_q <= '0;
            hold_q <= 1'b0;
            word_q <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (cmd_avail) begin
                        addr_q <= cmd_in.base;
                        left_q <= cmd_in.words;
                        hold_q <= cmd_in.hold_port;
                        state  <= (cmd_in.words == '0) ? after_last(cmd_in.hold_port) : SQ_FETCH;
                    end
                end
                SQ_FETCH: begin
                    if (mem_rsp_valid) begin
                        word_q <= mem_rsp_data;
                        state  <= SQ_SEND;
                    end
                end
                SQ_SEND: begin
                    if (cfg_ready) begin
                        addr_q <= addr_q + WORD_STEP;
                        left_q <= left_q - LEN_W'(1);
                        state  <= (left_q == LEN_W'(1)) ? after_last(hold_q) : SQ_FETCH;
                    end
                end
                SQ_WAITP: begin
                    if (port_idle) state <= SQ_FIN;
                end
                SQ_FIN:  state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_pop         = (state == SQ_IDLE) && cmd_avail;
        mem_req         = (state == SQ_FETCH);
        mem_addr        = addr_q;
        cfg_valid       = (state == SQ_SEND);
        cfg_data        = word_q;
        done_pulse      = (state == SQ_FIN);
        port_done_pulse = (state == SQ_FIN) && hold_q;
    end

endmodule

// File: rtl/cfgdma_cmdq.sv
module cfgdma_cmdq
    import cfgdma_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              cfg_valid,
    output logic [31:0]       cfg_data,
    input  logic              cfg_ready,
    input  logic              port_idle,
    output logic              q_full,
    output logic              q_empty,
    output logic              evt_dma_done,
    output logic              evt_port_done,
    output logic              evt_queue_ovf,
    output logic              evt_cmd_err
);

    localparam int CMD_W = $bits(cmd_t);

    logic push_req, push_legal, push_ok, pop;
    cmd_t push_cmd, head_cmd;
    logic [CMD_W-1:0] head_bits;
    logic ovf_q, err_q;

    cfgdma_regstage #(.REG_AW(REG_AW)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .push_req   (push_req),
        .push_legal (push_legal),
        .push_cmd   (push_cmd)
    );

    assign push_ok  = push_req && push_legal;
    assign head_cmd = cmd_t'(head_bits);

    cfgdma_cmd_fifo #(.DEPTH(DEPTH), .W(CMD_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push_ok),
        .din   (push_cmd),
        .pop   (pop),
        .dout  (head_bits),
        .full  (q_full),
        .empty (q_empty)
    );

    cfgdma_seq u_seq (
        .clk             (clk),
        .rst             (rst),
        .cmd_avail       (!q_empty),
        .cmd_in          (head_cmd),
        .cmd_pop         (pop),
        .mem_req         (mem_req),
        .mem_addr        (mem_addr),
        .mem_rsp_valid   (mem_rsp_valid),
        .mem_rsp_data    (mem_rsp_data),
        .cfg_valid       (cfg_valid),
        .cfg_data        (cfg_data),
        .cfg_ready       (cfg_ready),
        .port_idle       (port_idle),
        .done_pulse      (evt_dma_done),
        .port_done_pulse (evt_port_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            ovf_q <= push_ok && q_full;
            err_q <= push_req && !push_legal;
        end
    end

    assign evt_queue_ovf = ovf_q;
    assign evt_cmd_err   = err_q;

endmodule

// File: rtl/cfgdma_cmdq_chk.sv
module cfgdma_cmdq_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        cfg_valid,
    input logic [31:0] cfg_data,
    input logic        cfg_ready,
    input logic        q_full,
    input logic        q_empty,
    input logic        evt_dma_done,
    input logic        evt_port_done,
    input logic        evt_queue_ovf
);

    assert_hold_stream_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data)));

    assert_full_empty_R4: assert property (@(posedge clk) disable iff (rst)
        !(q_full && q_empty));

    assert_one_at_a_time_R4: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && cfg_valid));

    assert_fetch_flag_clear_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !mem_addr[0]);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        evt_dma_done |=> !evt_dma_done);

    assert_port_with_dma_R8: assert property (@(posedge clk) disable iff (rst)
        evt_port_done |-> evt_dma_done);

    assert_ovf_after_full_R5: assert property (@(posedge clk) disable iff (rst)
        evt_queue_ovf |-> $past(q_full));

endmodule

bind cfgdma_cmdq cfgdma_cmdq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .cfg_valid     (cfg_valid),
    .cfg_data      (cfg_data),
    .cfg_ready     (cfg_ready),
    .q_full        (q_full),
    .q_empty       (q_empty),
    .evt_dma_done  (evt_dma_done),
    .evt_port_done (evt_port_done),
    .evt_queue_ovf (evt_queue_ovf)
);

// File: tb/cfgdma_cmdq_test.sv
module cfgdma_cmdq_test;

    localparam int CLK_PERIOD = 10;
    localparam int MAXW = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        mem_req, mem_rsp_valid;
    logic [31:0] mem_addr, mem_rsp_data;
    logic        cfg_valid, cfg_ready;
    logic [31:0] cfg_data;
    logic        port_idle = 1'b1;
    logic        q_full, q_empty;
    logic        evt_dma_done, evt_port_done, evt_queue_ovf, evt_cmd_err;

    int checks = 0;
    int errors = 0;
    int ready_mode = 0;
    logic [15:0] lfsr;
    logic        gate;

    logic [31:0] got   [MAXW];
    logic [31:0] exp_w [MAXW];
    int n_got = 0, n_exp = 0;
    int dma_cnt = 0, pd_cnt = 0, ovf_cnt = 0, err_cnt = 0, req_cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgdma_cmdq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
        .cfg_ready(cfg_ready), .port_idle(port_idle), .q_full(q_full), .q_empty(q_empty),
        .evt_dma_done(evt_dma_done), .evt_port_done(evt_port_done),
        .evt_queue_ovf(evt_queue_ovf), .evt_cmd_err(evt_cmd_err)
    );

    function automatic logic [31:0] memf(logic [31:0] a);
        return (a * 32'd3) ^ 32'hC0DE0000;
    endfunction

    assign mem_rsp_data  = memf(mem_addr);
    assign mem_rsp_valid = mem_req && gate;

    always @(posedge clk) begin
        if (rst) begin
            lfsr      <= 16'hACE1;
            gate      <= 1'b1;
            cfg_ready <= 1'b1;
        end else begin
            lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            gate      <= lfsr[0] | lfsr[3];
            cfg_ready <= (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? 1'b0 : lfsr[5];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (cfg_valid && cfg_ready && n_got < MAXW) begin
                got[n_got] = cfg_data;
                n_got++;
            end
            if (mem_req) req_cycles++;
            if (evt_dma_done) dma_cnt++;
            if (evt_port_done) pd_cnt++;
            if (evt_queue_ovf) ovf_cnt++;
            if (evt_cmd_err) err_cnt++;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic issue(input logic [31:0] src, input logic [26:0] len, input logic accepted);
        reg_wr(8'h18, src);
        reg_wr(8'h1C, 32'hFFFFFFFF);
        reg_wr(8'h20, {5'd0, len});
        reg_wr(8'h24, 32'd0);
        if (accepted) begin
            for (int i = 0; i < int'(len); i++) begin
                exp_w[n_exp] = memf((src & ~32'd1) + 32'(4 * i));
                n_exp++;
            end
        end
    endtask

    task automatic wait_dones(input int target);
        for (int i = 0; i < 4000 && dma_cnt < target; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic compare_words(input string tag);
        check(n_got == n_exp, tag, 32'(n_got), 32'(n_exp));
        for (int i = 0; i < n_exp && i < n_got; i++)
            if (got[i] !== exp_w[i]) check(1'b0, tag, got[i], exp_w[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base_dma;
        int snap_got, snap_req, snap_pd;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check(q_empty == 1'b1, "R11 q_empty", 32'(q_empty), 1);
        check(q_full == 1'b0, "R11 q_full", 32'(q_full), 0);
        check(!cfg_valid && !mem_req, "R11 idle outputs", {30'd0, cfg_valid, mem_req}, 0);
        check(!evt_dma_done && !evt_queue_ovf && !evt_cmd_err, "R11 events", 32'(evt_dma_done), 0);

        // R1 staging writes alone do nothing
        reg_wr(8'h18, 32'h0000_0100);
        reg_wr(8'h1C, 32'hFFFF_FFFF);
        reg_wr(8'h20, 32'd4);
        repeat (10) @(negedge clk);
        check(q_empty == 1'b1, "R1 queue stays empty", 32'(q_empty), 1);
        check(n_got == 0 && req_cycles == 0, "R1 no activity", 32'(n_got + req_cycles), 0);

        // R2 destination-length write pushes
        reg_wr(8'h24, 32'd0);
        for (int i = 0; i < 4; i++) begin
            exp_w[n_exp] = memf(32'h100 + 32'(4 * i));
            n_exp++;
        end
        check(q_empty == 1'b0, "R2 push on dlen write", 32'(q_empty), 0);
        wait_dones(1);
        check(dma_cnt == 1, "R6 one done per command", 32'(dma_cnt), 1);
        compare_words("R3 first command words");
        check(pd_cnt == 0, "R8 no port done without flag", 32'(pd_cnt), 0);

        // R3 sweep over lengths and back-pressure patterns
        for (int m = 0; m < 3; m++) begin
            ready_mode = (m == 1) ? 2 : m * 2 / 2;
            if (m == 1) ready_mode = 2;
            for (int len = 1; len <= 6; len++) begin
                base_dma = dma_cnt;
                if (m == 2) ready_mode = (len % 2 == 0) ? 0 : 2;
                issue(32'h2000 + 32'(m * 32'h400) + 32'(len * 32'h40), 27'(len), 1'b1);
                wait_dones(base_dma + 1);
                check(dma_cnt == base_dma + 1, "R6 sweep done count", 32'(dma_cnt), 32'(base_dma + 1));
            end
        end
        compare_words("R3 sweep words");

        // R4 / R5 fill queue, overflow, order
        ready_mode = 1;
        base_dma = dma_cnt;
        for (int k = 0; k < 5; k++)
            issue(32'h3000 + 32'(k * 32'h100), 27'(k + 2), 1'b1);
        check(q_full == 1'b1, "R4 queue full at depth", 32'(q_full), 1);
        check(q_empty == 1'b0, "R4 not empty when full", 32'(q_empty), 0);
        issue(32'h3F00, 27'd3, 1'b0);
        repeat (3) @(negedge clk);
        check(ovf_cnt == 1, "R5 overflow event", 32'(ovf_cnt), 1);
        check(q_full == 1'b1, "R5 queue unchanged", 32'(q_full), 1);
        ready_mode = 2;
        wait_dones(base_dma + 5);
        check(dma_cnt == base_dma + 5, "R5 dropped command not run", 32'(dma_cnt), 32'(base_dma + 5));
        compare_words("R4 order of queued commands");
        check(ovf_cnt == 1, "R5 single overflow pulse", 32'(ovf_cnt), 1);

        // R7 zero length
        ready_mode = 0;
        snap_got = n_got; snap_req = req_cycles; base_dma = dma_cnt;
        issue(32'h4000, 27'd0, 1'b1);
        wait_dones(base_dma + 1);
        check(dma_cnt == base_dma + 1, "R7 zero length completes", 32'(dma_cnt), 32'(base_dma + 1));
        check(n_got == snap_got && req_cycles == snap_req, "R7 no transfer",
              32'(n_got - snap_got + req_cycles - snap_req), 0);

        // R8 wait-for-port flag
        port_idle = 1'b0;
        base_dma = dma_cnt; snap_pd = pd_cnt;
        issue(32'h5001, 27'd3, 1'b1);
        repeat (60) @(negedge clk);
        check(dma_cnt == base_dma, "R8 done held for port", 32'(dma_cnt), 32'(base_dma));
        compare_words("R8 flagged command words with bit0 cleared");
        port_idle = 1'b1;
        wait_dones(base_dma + 1);
        check(dma_cnt == base_dma + 1 && pd_cnt == snap_pd + 1, "R8 done and port done",
              32'(pd_cnt), 32'(snap_pd + 1));

        port_idle = 1'b0;
        base_dma = dma_cnt;
        issue(32'h5801, 27'd0, 1'b1);
        repeat (20) @(negedge clk);
        check(dma_cnt == base_dma, "R8 zero length waits for port", 32'(dma_cnt), 32'(base_dma));
        port_idle = 1'b1;
        wait_dones(base_dma + 1);
        check(pd_cnt == snap_pd + 2, "R8 zero length port done", 32'(pd_cnt), 32'(snap_pd + 2));

        port_idle = 1'b0;
        base_dma = dma_cnt;
        issue(32'h6000, 27'd2, 1'b1);
        wait_dones(base_dma + 1);
        check(dma_cnt == base_dma + 1, "R8 port ignored without flag", 32'(dma_cnt), 32'(base_dma + 1));
        check(pd_cnt == snap_pd + 2, "R8 no port done without flag", 32'(pd_cnt), 32'(snap_pd + 2));
        port_idle = 1'b1;

        // R9 destination code
        snap_got = n_got;
        reg_wr(8'h18, 32'h7000);
        reg_wr(8'h1C, 32'h0000_6000);
        reg_wr(8'h20, 32'd2);
        reg_wr(8'h24, 32'd0);
        repeat (20) @(negedge clk);
        check(err_cnt == 1, "R9 real destination rejected", 32'(err_cnt), 1);
        check(q_empty == 1'b1 && n_got == snap_got, "R9 no command queued", 32'(n_got - snap_got), 0);
        reg_wr(8'h1C, 32'hFFFF_FFFF);
        reg_wr(8'h24, 32'd1);
        repeat (20) @(negedge clk);
        check(err_cnt == 2, "R9 nonzero destination length rejected", 32'(err_cnt), 2);
        check(n_got == snap_got, "R9 nothing streamed", 32'(n_got), 32'(snap_got));

        // R3 length field width: bit 27 ignored
        base_dma = dma_cnt;
        reg_wr(8'h20, 32'h0800_0002);
        reg_wr(8'h24, 32'd0);
        exp_w[n_exp] = memf(32'h7000); n_exp++;
        exp_w[n_exp] = memf(32'h7004); n_exp++;
        wait_dones(base_dma + 1);
        compare_words("R3 length field 27 bits");
        check(q_empty == 1'b1 && q_full == 1'b0, "R4 queue drained", {30'd0, q_full, q_empty}, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule